// File: doc/BRIEF.md
# Masked calendar alarm comparator

This block watches a live BCD calendar and raises an alarm interrupt when the calendar reaches a programmed moment. Software programs six alarm field values (seconds, minutes, hours, day of month, month and a three-digit year), a per-field compare mask and a global enable through a small synchronous register port. On every one-second strobe from the calendar counter, each field whose mask bit is set is compared against the current calendar value. When all selected fields agree, a sticky pending bit is set and the interrupt line goes high.

The pending bit stays set until software writes a one to its position in the pending register. The calendar counter itself and any periodic tick generator sit outside this block; it only consumes the strobe and the current calendar fields.

Top module: `cal_alarm_unit`

## Requirements
- R1: After reset the compare control, all six alarm fields and the pending bit are zero, and the interrupt line is low.
- R2: Alarm field writes keep only their low bits: seconds 7, minutes 7, hours 6, day 6, month 5, year 12; the control register keeps its low 7 bits. Register addresses: 0 control, 1 seconds, 2 minutes, 3 hours, 4 day, 5 month, 6 year, 7 pending.
- R3: Control bit 6 is the global alarm enable; while it is clear no alarm is raised whatever the calendar and mask.
- R4: Control bits 0 to 5 select comparison of seconds, minutes, hours, day, month and year respectively; a field whose bit is clear is ignored.
- R5: The alarm fires only if every selected field matches and at least one field bit in control bits 0 to 5 is set.
- R6: Comparison happens only in a cycle where the one-second strobe is high.
- R7: The year is compared as a 12-bit value, three BCD digits: bits 11:8 the hundreds digit, bits 7:0 tens and units.
- R8: A match in a strobe cycle sets the pending bit and the interrupt line on the next clock edge; both stay high until cleared.
- R9: A write to address 7 with bit 1 set clears the pending bit and lowers the line on the next edge; a write with bit 1 clear has no effect on it.
- R10: If a match and a clearing write occur in the same cycle, the pending bit is set after that edge.
- R11: Reading address 7 returns the pending bit at bit 1 and zero elsewhere; reads of addresses 8 and above return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle strobe when the calendar advances by a second |
| cal_sec | input | 8 | Current seconds, BCD |
| cal_min | input | 8 | Current minutes, BCD |
| cal_hour | input | 8 | Current hours, BCD |
| cal_day | input | 8 | Current day of month, BCD |
| cal_mon | input | 8 | Current month, BCD |
| cal_year | input | 12 | Current year, three BCD digits |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (4) | Register address |
| reg_wdata | input | DATA_W (16) | Register write data |
| reg_rdata | output | DATA_W (16) | Register read data, combinational on address |
| alarm_pending | output | 1 | Sticky alarm pending bit |
| alarm_irq | output | 1 | Alarm interrupt line |

## Verification
The assertions assume the strobe and the calendar fields are sampled only at clock edges with no relation between them beyond what the requirements state, and that reset is held for at least one edge before the first check. They take the comparator's own match signal as the event that must set the pending bit, so a clear-and-match cycle is judged against that signal. The stimulus drives all inputs on the falling edge, keeps the register address within four bits, and biases the calendar toward the programmed alarm values so that matches, near misses on single fields and clear collisions all occur.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;

    localparam int NUM_FIELDS     = 6;
    localparam int FIELD_BITS     = 12;
    localparam int CTRL_BITS      = 7;
    localparam int GLOBAL_EN_BIT  = 6;
    localparam int PEND_ALARM_BIT = 1;

    // register map
    localparam int ADDR_CTRL = 0;
    localparam int ADDR_FLD0 = 1;
    localparam int ADDR_PEND = 7;

    typedef logic [FIELD_BITS-1:0] fld_t;

    typedef struct packed {
        logic                  glob_en;
        logic [NUM_FIELDS-1:0] mask;
    } ctrl_t;

    // bits kept by each alarm field on a write
    function automatic fld_t keep_mask(input int idx);
        case (idx)
            0:       return fld_t'(12'h07F);
            1:       return fld_t'(12'h07F);
            2:       return fld_t'(12'h03F);
            3:       return fld_t'(12'h03F);
            4:       return fld_t'(12'h01F);
            default: return fld_t'(12'hFFF);
        endcase
    endfunction

endpackage

// File: rtl/cal_alarm_regs.sv
module cal_alarm_regs
    import cal_alarm_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         we,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [DATA_W-1:0]            wdata,
    input  logic                         pend,
    output ctrl_t                        ctrl_o,
    output fld_t [NUM_FIELDS-1:0]        fld_o,
    output logic [DATA_W-1:0]            rdata
);

    ctrl_t ctrl_q;
    fld_t [NUM_FIELDS-1:0] fld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (we && (int'(addr) == ADDR_CTRL)) begin
            ctrl_q <= ctrl_t'(wdata[CTRL_BITS-1:0]);
        end
    end

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_fld
        always_ff @(posedge clk) begin
            if (rst) begin
                fld_q[i] <= '0;
            end else if (we && (int'(addr) == ADDR_FLD0 + i)) begin
                fld_q[i] <= wdata[FIELD_BITS-1:0] & keep_mask(i);
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (int'(addr) == ADDR_CTRL) begin
            rdata = DATA_W'(ctrl_q);
        end else if (int'(addr) == ADDR_PEND) begin
            rdata[PEND_ALARM_BIT] = pend;
        end else begin
            for (int k = 0; k < NUM_FIELDS; k++) begin
                if (int'(addr) == ADDR_FLD0 + k) begin
                    rdata = DATA_W'(fld_q[k]);
                end
            end
        end
    end

    assign ctrl_o = ctrl_q;
    assign fld_o  = fld_q;

endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match
    import cal_alarm_pkg::*;
(
    input  logic                  tick,
    input  ctrl_t                 ctrl,
    input  fld_t [NUM_FIELDS-1:0] alarm,
    input  fld_t [NUM_FIELDS-1:0] cal,
    output logic                  hit
);

    logic [NUM_FIELDS-1:0] agree;

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_cmp
        assign agree[i] = !ctrl.mask[i] || (cal[i] == alarm[i]);
    end

    assign hit = tick && ctrl.glob_en && (|ctrl.mask) && (&agree);

endmodule

// File: rtl/cal_alarm_pend.sv
module cal_alarm_pend (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);

    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= set_i || (pend_q && !clr_i);
        end
    end

    assign pend_o = pend_q;

endmodule

// File: rtl/cal_alarm_unit.sv
module cal_alarm_unit
    import cal_alarm_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sec_tick,
    input  logic [7:0]        cal_sec,
    input  logic [7:0]        cal_min,
    input  logic [7:0]        cal_hour,
    input  logic [7:0]        cal_day,
    input  logic [7:0]        cal_mon,
    input  logic [11:0]       cal_year,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              alarm_pending,
    output logic              alarm_irq
);

    ctrl_t                 ctrl_q;
    fld_t [NUM_FIELDS-1:0] alarm_fld;
    fld_t [NUM_FIELDS-1:0] cal_vec;
    logic                  hit_w;
    logic                  clr_w;
    logic                  pend_w;

    assign cal_vec[0] = fld_t'(cal_sec);
    assign cal_vec[1] = fld_t'(cal_min);
    assign cal_vec[2] = fld_t'(cal_hour);
    assign cal_vec[3] = fld_t'(cal_day);
    assign cal_vec[4] = fld_t'(cal_mon);
    assign cal_vec[5] = cal_year;

    assign clr_w = reg_we && (int'(reg_addr) == ADDR_PEND) && reg_wdata[PEND_ALARM_BIT];

    cal_alarm_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (reg_we),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .pend   (pend_w),
        .ctrl_o (ctrl_q),
        .fld_o  (alarm_fld),
        .rdata  (reg_rdata)
    );

    cal_alarm_match u_match (
        .tick  (sec_tick),
        .ctrl  (ctrl_q),
        .alarm (alarm_fld),
        .cal   (cal_vec),
        .hit   (hit_w)
    );

    cal_alarm_pend u_pend (
        .clk    (clk),
        .rst    (rst),
        .set_i  (hit_w),
        .clr_i  (clr_w),
        .pend_o (pend_w)
    );

    assign alarm_pending = pend_w;
    assign alarm_irq     = pend_w;

endmodule

// File: rtl/cal_alarm_chk.sv
module cal_alarm_chk #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              sec_tick,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              alarm_pending,
    input logic [6:0]        ctrl_bits,
    input logic              hit
);

    logic clr_req;
    assign clr_req = reg_we && (int'(reg_addr) == 7) && reg_wdata[1];

    a_r6_rise_needs_tick: assert property (@(posedge clk) disable iff (rst)
        $rose(alarm_pending) |-> $past(sec_tick));

    a_r3_rise_needs_global: assert property (@(posedge clk) disable iff (rst)
        $rose(alarm_pending) |-> $past(ctrl_bits[6]));

    a_r5_rise_needs_mask: assert property (@(posedge clk) disable iff (rst)
        $rose(alarm_pending) |-> ($past(ctrl_bits[5:0]) != 6'd0));

    a_r10_event_wins: assert property (@(posedge clk) disable iff (rst)
        hit |=> alarm_pending);

    a_r9_clear_lowers: assert property (@(posedge clk) disable iff (rst)
        (clr_req && !hit) |=> !alarm_pending);

    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        (alarm_pending && !clr_req) |=> alarm_pending);

endmodule

bind cal_alarm_unit cal_alarm_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .sec_tick      (sec_tick),
    .reg_we        (reg_we),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .alarm_pending (alarm_pending),
    .ctrl_bits     (ctrl_q),
    .hit           (hit_w)
);

// File: tb/cal_alarm_unit_test.sv
`timescale 1ns/1ps
module cal_alarm_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sec_tick = 1'b0;
    logic [7:0]  cal_sec = '0, cal_min = '0, cal_hour = '0, cal_day = '0, cal_mon = '0;
    logic [11:0] cal_year = '0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        alarm_pending, alarm_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [6:0]  m_ctrl;
    logic [11:0] m_fld [6];
    logic        m_pend;

    always #2 clk = ~clk;

    cal_alarm_unit uut (
        .clk(clk), .rst(rst), .sec_tick(sec_tick),
        .cal_sec(cal_sec), .cal_min(cal_min), .cal_hour(cal_hour),
        .cal_day(cal_day), .cal_mon(cal_mon), .cal_year(cal_year),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .alarm_pending(alarm_pending), .alarm_irq(alarm_irq)
    );

    function automatic logic [11:0] keep(input int i);
        case (i)
            0, 1:    return 12'h07F;
            2, 3:    return 12'h03F;
            4:       return 12'h01F;
            default: return 12'hFFF;
        endcase
    endfunction

    function automatic logic exp_fire(input logic tk, input logic [11:0] c [6]);
        logic ok;
        ok = tk && m_ctrl[6] && (m_ctrl[5:0] != 0);
        for (int i = 0; i < 6; i++)
            if (m_ctrl[i] && (c[i] != m_fld[i])) ok = 1'b0;
        return ok;
    endfunction

    function automatic logic [15:0] exp_read(input int a);
        if (a == 0) return {9'd0, m_ctrl};
        if (a >= 1 && a <= 6) return {4'd0, m_fld[a-1]};
        if (a == 7) return {14'd0, m_pend, 1'b0};
        return 16'd0;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // one clock: drive on falling edge, sample just after rising edge
    task automatic step(input string req, input logic we, input logic [3:0] a,
                        input logic [15:0] d, input logic tk, input logic [11:0] c [6]);
        logic f, clr;
        @(negedge clk);
        reg_we = we; reg_addr = a; reg_wdata = d; sec_tick = tk;
        cal_sec = c[0][7:0]; cal_min = c[1][7:0]; cal_hour = c[2][7:0];
        cal_day = c[3][7:0]; cal_mon = c[4][7:0]; cal_year = c[5];
        f = exp_fire(tk, c);
        clr = we && (a == 4'd7) && d[1];
        @(posedge clk); #1;
        if (we && a == 4'd0) m_ctrl = d[6:0];
        if (we && a >= 4'd1 && a <= 4'd6) m_fld[a-1] = d[11:0] & keep(int'(a) - 1);
        m_pend = f || (m_pend && !clr);
        check({req, " pending"}, alarm_pending, m_pend);
        check({req, " irq"}, alarm_irq, m_pend);
        reg_we = 1'b0; sec_tick = 1'b0;
    endtask

    task automatic rd(input string req, input logic [3:0] a);
        @(negedge clk);
        reg_we = 1'b0; sec_tick = 1'b0; reg_addr = a;
        #1;
        check(req, reg_rdata, exp_read(int'(a)));
    endtask

    task automatic wr(input string req, input logic [3:0] a, input logic [15:0] d);
        logic [11:0] z [6];
        for (int i = 0; i < 6; i++) z[i] = 12'h0;
        step(req, 1'b1, a, d, 1'b0, z);
    endtask

    initial begin
        #80000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [11:0] c [6];
        int unsigned seed;
        void'($urandom(32'h5A17));
        m_ctrl = '0; m_pend = 1'b0;
        for (int i = 0; i < 6; i++) m_fld[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1 reset state
        check("R1 pending", alarm_pending, 1'b0);
        check("R1 irq", alarm_irq, 1'b0);
        for (int a = 0; a < 8; a++) rd("R1 read", 4'(a));

        // R2 truncation and readback
        wr("R2 ctrl", 4'd0, 16'hFFFF);
        for (int a = 1; a <= 6; a++) wr("R2 field", 4'(a), 16'hFFFF);
        for (int a = 0; a <= 6; a++) rd("R2 readback", 4'(a));

        // program alarm: 12:15:30, day 21, month 09, year 225
        wr("R2 ctrl off", 4'd0, 16'h0000);
        wr("R2 sec", 4'd1, 16'h0030);
        wr("R2 min", 4'd2, 16'h0015);
        wr("R2 hour", 4'd3, 16'h0012);
        wr("R2 day", 4'd4, 16'h0021);
        wr("R2 mon", 4'd5, 16'h0009);
        wr("R2 year", 4'd6, 16'h0225);
        c[0] = 12'h030; c[1] = 12'h015; c[2] = 12'h012;
        c[3] = 12'h021; c[4] = 12'h009; c[5] = 12'h225;

        // R3 global enable clear
        wr("R3 ctrl", 4'd0, 16'h003F);
        step("R3 no global", 1'b0, 4'd0, 16'h0, 1'b1, c);

        // R4 only seconds selected, others mismatch
        wr("R4 ctrl", 4'd0, 16'h0041);
        c[1] = 12'h059; c[5] = 12'h199;
        step("R4 sec only fires", 1'b0, 4'd0, 16'h0, 1'b1, c);
        step("R8 sticky", 1'b0, 4'd0, 16'h0, 1'b0, c);
        rd("R11 pend read", 4'd7);
        rd("R11 unmapped", 4'd9);
        step("R9 write zero", 1'b1, 4'd7, 16'hFFFD, 1'b0, c);
        step("R9 clear", 1'b1, 4'd7, 16'h0002, 1'b0, c);

        // R5 all fields, one mismatch
        wr("R5 ctrl", 4'd0, 16'h007F);
        c[1] = 12'h015;
        c[5] = 12'h125;
        step("R7 hundreds differ", 1'b0, 4'd0, 16'h0, 1'b1, c);
        c[5] = 12'h225; c[2] = 12'h013;
        step("R5 hour mismatch", 1'b0, 4'd0, 16'h0, 1'b1, c);
        c[2] = 12'h012;
        step("R6 no tick", 1'b0, 4'd0, 16'h0, 1'b0, c);
        step("R7 full year match", 1'b0, 4'd0, 16'h0, 1'b1, c);
        step("R9 clear", 1'b1, 4'd7, 16'h0002, 1'b0, c);

        // R5 empty mask
        wr("R5 ctrl empty", 4'd0, 16'h0040);
        step("R5 empty mask", 1'b0, 4'd0, 16'h0, 1'b1, c);

        // R10 match with clear in same cycle
        wr("R10 ctrl", 4'd0, 16'h0060);
        step("R10 arm", 1'b0, 4'd0, 16'h0, 1'b1, c);
        step("R10 event wins", 1'b1, 4'd7, 16'h0002, 1'b1, c);
        step("R10 then clear", 1'b1, 4'd7, 16'h0002, 1'b0, c);

        // random mix
        for (int n = 0; n < 600; n++) begin
            int op;
            logic [11:0] rc [6];
            op = int'($urandom_range(0, 9));
            for (int i = 0; i < 6; i++) begin
                rc[i] = m_fld[i];
                if ($urandom_range(0, 5) == 0) rc[i] = 12'($urandom) & keep(i);
            end
            if (op == 0) begin
                logic [15:0] d;
                d = 16'($urandom);
                if ($urandom_range(0, 3) != 0) d[6] = 1'b1;
                step("R4 rnd ctrl", 1'b1, 4'd0, d, 1'b0, rc);
            end else if (op == 1) begin
                step("R2 rnd field", 1'b1, 4'($urandom_range(1, 6)), 16'($urandom), 1'b0, rc);
            end else if (op == 2) begin
                step("R9 rnd clear", 1'b1, 4'd7, 16'($urandom), $urandom_range(0, 1) == 1, rc);
            end else if (op == 3) begin
                rd("R11 rnd read", 4'($urandom_range(0, 15)));
            end else begin
                step("R5 rnd tick", 1'b0, 4'd0, 16'h0, $urandom_range(0, 3) != 0, rc);
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule